// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block is the coherence controller of one core's private cache. It holds a direct-mapped array of lines, each one word wide, and tracks a four-state MESI tag for every line: Invalid, Shared, Exclusive-clean and Modified. Loads and stores from the local core arrive on a request port. The core holds each request until the block returns a one-cycle done pulse. When a request needs the rest of the system, the block raises a bus request with a read, read-for-ownership or write-back command and waits for the grant. The grant completes the transaction in a single step. For a read, memory data and the wired-OR shared line are sampled in the grant cycle.

At the same time the block watches transactions that other caches put on the shared bus. A snooped read of a line the block holds makes it assert the shared line, and a dirty line is downgraded to Shared. A snooped read-for-ownership invalidates the local copy. In both cases a Modified line is first written back on a dedicated write-back output, so memory holds current data when it answers the requester.

A read miss fills the line as Exclusive when no other cache claims a copy. A later store to that line is then performed locally with no bus traffic.

Top module: `mesi_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus request, done pulse, write-back or shared reply is active, and a snooped read of any address gets no shared reply.
- R2: A load that misses issues one bus request with command 01 (read) for the load address. The line is filled with the granted data in state Exclusive when bus_shared is low at the grant, and in state Shared when it is high. The load returns the granted data.
- R3: A store to a line that is Invalid or Shared issues one bus request with command 10 (read-for-ownership) before it completes, and leaves the line Modified holding the store data. This holds even when the Shared copy is valid.
- R4: A store to a line in Exclusive completes with no bus request and leaves the line Modified.
- R5: A load hit in Shared, Exclusive or Modified, and a store hit in Modified, raise no bus request and give cpu_done one cycle after the request is presented. A load returns the line data, and a store echoes its data on cpu_rdata.
- R6: A snooped read (snp_cmd 01) that hits a Modified line writes the line back on the wb port one cycle later and leaves it Shared. One that hits an Exclusive line leaves it Shared with no write-back.
- R7: A snooped read-for-ownership (snp_cmd 10) that hits a valid line leaves it Invalid. The line is written back first only when it was Modified.
- R8: snp_shared is high one cycle after a snooped read that hits a valid line, and low after a snooped read-for-ownership or a snoop that misses.
- R9: A miss whose direct-mapped frame holds a Modified line of another tag first issues command 11 (write-back) with the victim address and data, then the fill request. A Shared or Exclusive victim is dropped with no bus request.
- R10: A snoop presented in the same cycle as a local request is applied first, and the local request is then served against the updated state.
- R11: A snoop whose index matches a line but whose tag differs leaves that line unchanged and produces neither a write-back nor a shared reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Local request valid, held until cpu_done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result or echoed store data |
| bus_req | output | 1 | Bus request, held until bus_gnt |
| bus_cmd | output | 2 | 01 read, 10 read-for-ownership, 11 write-back |
| bus_addr | output | ADDR_W | Address of the bus transaction |
| bus_wdata | output | DATA_W | Data of a write-back |
| bus_gnt | input | 1 | Grant; completes the transaction in that cycle |
| bus_rdata | input | DATA_W | Memory data, valid with bus_gnt |
| bus_shared | input | 1 | Wired-OR shared line, valid with bus_gnt |
| snp_valid | input | 1 | Remote transaction on the bus |
| snp_cmd | input | 2 | Remote command, same coding as bus_cmd |
| snp_addr | input | ADDR_W | Remote transaction address |
| snp_shared | output | 1 | This cache holds the snooped line (read only) |
| wb_valid | output | 1 | Snoop-forced write-back of a dirty line |
| wb_addr | output | ADDR_W | Address of the written-back line |
| wb_data | output | DATA_W | Data of the written-back line |

## Verification
The line state is not visible at the ports, so the bench infers it from traffic. A store that draws a read-for-ownership proves a line was Shared, a silent store proves Exclusive, and a load that misses proves Invalid. Each test drives a line into a target state, applies one snoop, then probes it this way. If E and S are confused after a read miss with the shared line high, a later store goes out silently where a read-for-ownership is expected. If a dirty line is downgraded without a write-back, wb_valid never pulses. The eviction case catches a design that fills over a dirty victim, because the write-back request never appears. It also catches one that writes back clean victims, because two bus requests appear where one is expected. A snoop to the same index with a different tag must leave the line a silent hit. The same-cycle snoop/load case exposes a design that serves the load from the stale Modified copy: its load would hit instead of issuing a read.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_RD    = 2'd1,
    CMD_RDX   = 2'd2,
    CMD_FLUSH = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [1:0]        a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [1:0]        b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [1:0]        st_val,
  input  logic              td_we,
  input  logic [IDX_W-1:0]  td_idx,
  input  logic [TAG_W-1:0]  td_tag,
  input  logic [DATA_W-1:0] td_data
);
  localparam int LINES = 1 << IDX_W;

  logic [1:0]        state_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [DATA_W-1:0] data_q  [LINES];

  // state bits need a reset; tag and data do not, so they stay RAM-shaped
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) state_q[i] <= 2'd0;
    end else if (st_we) begin
      state_q[st_idx] <= st_val;
    end
  end

  always_ff @(posedge clk) begin
    if (td_we) begin
      tag_q[td_idx]  <= td_tag;
      data_q[td_idx] <= td_data;
    end
  end

  assign a_state = state_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = data_q[a_idx];
  assign b_state = state_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = data_q[b_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 9
) (
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [1:0]       line_state,
  input  logic [TAG_W-1:0] line_tag,
  output logic             sn_st_we,
  output logic [1:0]       sn_st_val,
  output logic             sn_flush,
  output logic             sn_shared
);
  logic sn_hit;

  always_comb begin
    sn_hit    = snp_valid && (line_state != ST_I) && (line_tag == snp_tag);
    sn_st_we  = 1'b0;
    sn_st_val = line_state;
    sn_flush  = 1'b0;
    sn_shared = 1'b0;
    if (sn_hit) begin
      if (snp_cmd == CMD_RD) begin
        sn_shared = 1'b1;
        if (line_state == ST_M || line_state == ST_E) begin
          sn_st_we  = 1'b1;
          sn_st_val = ST_S;
          sn_flush  = (line_state == ST_M);
        end
      end else if (snp_cmd == CMD_RDX) begin
        sn_st_we  = 1'b1;
        sn_st_val = ST_I;
        sn_flush  = (line_state == ST_M);
      end
    end
  end
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_done,
  output logic [DATA_W-1:0]       cpu_rdata,
  input  logic                    snp_valid,
  input  logic                    snp_same_idx,
  input  logic [1:0]              line_state,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  input  logic [DATA_W-1:0]       line_data,
  output logic                    bus_req,
  output logic [1:0]              bus_cmd,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_gnt,
  input  logic [DATA_W-1:0]       bus_rdata,
  input  logic                    bus_shared,
  output logic                    st_we,
  output logic [1:0]              st_val,
  output logic                    td_we,
  output logic [ADDR_W-IDX_W-1:0] td_tag,
  output logic [DATA_W-1:0]       td_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {F_IDLE, F_FILL, F_EVICT} fsm_t;
  fsm_t fsm_q;

  logic [TAG_W-1:0] req_tag;
  logic hit, idle_go, owned;

  assign req_tag = cpu_addr[ADDR_W-1:IDX_W];

  always_comb begin
    hit     = (line_state != ST_I) && (line_tag == req_tag);
    owned   = (line_state == ST_M) || (line_state == ST_E);
    // a snoop in this cycle wins; the request is replayed next cycle
    idle_go = (fsm_q == F_IDLE) && cpu_req && !cpu_done && !snp_valid;
    st_we   = 1'b0;
    st_val  = ST_I;
    td_we   = 1'b0;
    td_tag  = req_tag;
    td_data = cpu_wdata;
    if (idle_go && cpu_we && hit && owned) begin
      st_we  = 1'b1;
      st_val = ST_M;
      td_we  = 1'b1;
    end
    if (fsm_q == F_FILL && bus_gnt) begin
      st_we = 1'b1;
      td_we = 1'b1;
      if (bus_cmd == CMD_RD) begin
        st_val  = bus_shared ? ST_S : ST_E;
        td_data = bus_rdata;
      end else begin
        st_val = ST_M;
      end
    end
    if (fsm_q == F_EVICT && bus_gnt) begin
      st_we  = 1'b1;
      st_val = ST_I;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q     <= F_IDLE;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      bus_req   <= 1'b0;
      bus_cmd   <= CMD_NONE;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (fsm_q)
        F_IDLE: begin
          if (idle_go) begin
            if (hit && (!cpu_we || owned)) begin
              cpu_done  <= 1'b1;
              cpu_rdata <= cpu_we ? cpu_wdata : line_data;
            end else if (line_state == ST_M && !hit) begin
              bus_req   <= 1'b1;
              bus_cmd   <= CMD_FLUSH;
              bus_addr  <= {line_tag, cpu_addr[IDX_W-1:0]};
              bus_wdata <= line_data;
              fsm_q     <= F_EVICT;
            end else begin
              bus_req   <= 1'b1;
              bus_cmd   <= cpu_we ? CMD_RDX : CMD_RD;
              bus_addr  <= cpu_addr;
              bus_wdata <= '0;
              fsm_q     <= F_FILL;
            end
          end
        end
        F_FILL: begin
          if (bus_gnt) begin
            bus_req   <= 1'b0;
            cpu_done  <= 1'b1;
            cpu_rdata <= (bus_cmd == CMD_RD) ? bus_rdata : cpu_wdata;
            fsm_q     <= F_IDLE;
          end
        end
        F_EVICT: begin
          if (bus_gnt) begin
            bus_req <= 1'b0;
            fsm_q   <= F_IDLE;
          end else if (snp_valid && snp_same_idx) begin
            // victim may have been flushed or downgraded: drop and replay
            bus_req <= 1'b0;
            fsm_q   <= F_IDLE;
          end
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  snp_tag;
  logic [1:0]        a_state, b_state;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;

  logic              lc_st_we, lc_td_we;
  logic [1:0]        lc_st_val;
  logic [TAG_W-1:0]  lc_td_tag;
  logic [DATA_W-1:0] lc_td_data;

  logic              sn_st_we, sn_flush, sn_shared;
  logic [1:0]        sn_st_val;

  logic              st_we;
  logic [IDX_W-1:0]  st_idx;
  logic [1:0]        st_val;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  // snoop updates take precedence on the single state write port
  always_comb begin
    if (sn_st_we) begin
      st_we  = 1'b1;
      st_idx = snp_idx;
      st_val = sn_st_val;
    end else begin
      st_we  = lc_st_we;
      st_idx = cpu_idx;
      st_val = lc_st_val;
    end
  end

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .a_idx   (cpu_idx),
    .a_state (a_state),
    .a_tag   (a_tag),
    .a_data  (a_data),
    .b_idx   (snp_idx),
    .b_state (b_state),
    .b_tag   (b_tag),
    .b_data  (b_data),
    .st_we   (st_we),
    .st_idx  (st_idx),
    .st_val  (st_val),
    .td_we   (lc_td_we),
    .td_idx  (cpu_idx),
    .td_tag  (lc_td_tag),
    .td_data (lc_td_data)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_tag    (snp_tag),
    .line_state (b_state),
    .line_tag   (b_tag),
    .sn_st_we   (sn_st_we),
    .sn_st_val  (sn_st_val),
    .sn_flush   (sn_flush),
    .sn_shared  (sn_shared)
  );

  mesi_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_done     (cpu_done),
    .cpu_rdata    (cpu_rdata),
    .snp_valid    (snp_valid),
    .snp_same_idx (snp_idx == cpu_idx),
    .line_state   (a_state),
    .line_tag     (a_tag),
    .line_data    (a_data),
    .bus_req      (bus_req),
    .bus_cmd      (bus_cmd),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_gnt      (bus_gnt),
    .bus_rdata    (bus_rdata),
    .bus_shared   (bus_shared),
    .st_we        (lc_st_we),
    .st_val       (lc_st_val),
    .td_we        (lc_td_we),
    .td_tag       (lc_td_tag),
    .td_data      (lc_td_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_shared <= 1'b0;
      wb_valid   <= 1'b0;
      wb_addr    <= '0;
      wb_data    <= '0;
    end else begin
      snp_shared <= sn_shared;
      wb_valid   <= sn_flush;
      if (sn_flush) begin
        wb_addr <= snp_addr;
        wb_data <= b_data;
      end
    end
  end
endmodule

// File: rtl/mesi_ctrl_chk.sv
module mesi_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_shared,
  input logic              wb_valid
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_req && !cpu_done && !wb_valid && !snp_shared));

  assert_cmd_legal_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_cmd != 2'd0));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  assert_wb_after_snoop_R7: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(snp_valid && snp_cmd != 2'd0 && snp_cmd != 2'd3));

  assert_shared_on_read_R8: assert property (@(posedge clk) disable iff (rst)
    snp_shared |-> $past(snp_valid && snp_cmd == 2'd1));

  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt && !snp_valid) |=>
      (bus_req && $stable(bus_cmd) && $stable(bus_addr)));
endmodule

bind mesi_ctrl mesi_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_done   (cpu_done),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_cmd    (bus_cmd),
  .bus_addr   (bus_addr),
  .snp_valid  (snp_valid),
  .snp_cmd    (snp_cmd),
  .snp_shared (snp_shared),
  .wb_valid   (wb_valid)
);

// File: tb/mesi_ctrl_tb.sv
module mesi_ctrl_tb;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [1:0] RD = 2'd1, RDX = 2'd2, FL = 2'd3;

  logic clk, rst;
  logic cpu_req, cpu_we, cpu_done;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic bus_req, bus_gnt, bus_shared;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic snp_valid, snp_shared, wb_valid;
  logic [1:0] snp_cmd;
  logic [AW-1:0] snp_addr, wb_addr;
  logic [DW-1:0] wb_data;

  mesi_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(3)) u_dut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_shared(bus_shared),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {20'hBEEF0, a};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // bus/memory agent: grants each request two cycles after it appears
  logic [1:0]    lg_cmd [8];
  logic [AW-1:0] lg_adr [8];
  logic [DW-1:0] lg_dat [8];
  int  n_bus = 0;
  bit  shr_drive = 0;
  int  dly = 0;

  initial begin
    bus_gnt = 0; bus_rdata = '0; bus_shared = 0;
    forever begin
      @(negedge clk);
      if (bus_gnt) begin
        bus_gnt = 0;
        bus_shared = 0;
      end else if (bus_req && !rst) begin
        if (dly == 1) begin
          if (n_bus < 8) begin
            lg_cmd[n_bus] = bus_cmd;
            lg_adr[n_bus] = bus_addr;
            lg_dat[n_bus] = bus_wdata;
          end
          n_bus++;
          bus_gnt = 1;
          bus_rdata = pat(bus_addr);
          bus_shared = shr_drive;
          dly = 0;
        end else dly++;
      end
    end
  end

  logic [DW-1:0] op_rdata;
  int op_cyc;

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    n_bus = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    op_cyc = 0;
    do begin
      @(negedge clk);
      op_cyc++;
    end while (!cpu_done && op_cyc < 200);
    op_rdata = cpu_rdata;
    cpu_req = 0;
  endtask

  bit sn_sh, sn_wb;
  logic [AW-1:0] sn_wa;
  logic [DW-1:0] sn_wd;

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    sn_sh = snp_shared; sn_wb = wb_valid; sn_wa = wb_addr; sn_wd = wb_data;
    snp_valid = 0; snp_cmd = 0;
  endtask

  task automatic t_reset();
    chk(!bus_req && !cpu_done && !wb_valid && !snp_shared, "R1 idle outputs",
        {bus_req, cpu_done, wb_valid, snp_shared}, 0);
    snoop(RD, 12'h010);
    chk(!sn_sh && !sn_wb, "R1 all lines invalid", {sn_sh, sn_wb}, 0);
  endtask

  task automatic t_read_excl();
    shr_drive = 0;
    cpu_op(0, 12'h010, 0);
    chk(n_bus == 1 && lg_cmd[0] == RD && lg_adr[0] == 12'h010, "R2 read miss issues read",
        {n_bus[7:0], 6'd0, lg_cmd[0], 4'd0, lg_adr[0]}, {8'd1, 8'd1, 16'h0010});
    chk(op_rdata == pat(12'h010), "R2 read miss data", op_rdata, pat(12'h010));
    cpu_op(1, 12'h010, 32'h1111_0001);
    chk(n_bus == 0, "R4 store in E silent", n_bus, 0);
    cpu_op(0, 12'h010, 0);
    chk(n_bus == 0 && op_cyc == 1, "R5 load hit in M one cycle", {n_bus[15:0], op_cyc[15:0]}, {16'd0, 16'd1});
    chk(op_rdata == 32'h1111_0001, "R5 load hit data", op_rdata, 32'h1111_0001);
  endtask

  task automatic t_read_shared();
    shr_drive = 1;
    cpu_op(0, 12'h021, 0);
    shr_drive = 0;
    chk(n_bus == 1 && lg_cmd[0] == RD, "R2 read miss shared", n_bus, 1);
    cpu_op(0, 12'h021, 0);
    chk(n_bus == 0 && op_cyc == 1, "R5 load hit in S", n_bus, 0);
    cpu_op(1, 12'h021, 32'h2222_0002);
    chk(n_bus == 1 && lg_cmd[0] == RDX, "R2 line filled as S, R3 store in S needs RdX",
        lg_cmd[0], RDX);
    cpu_op(0, 12'h021, 0);
    chk(n_bus == 0 && op_rdata == 32'h2222_0002, "R3 line M after upgrade", op_rdata, 32'h2222_0002);
  endtask

  task automatic t_snoop_rd_m();
    cpu_op(1, 12'h032, 32'h3333_0003);
    chk(n_bus == 1 && lg_cmd[0] == RDX && lg_adr[0] == 12'h032, "R3 store miss RdX", lg_cmd[0], RDX);
    snoop(RD, 12'h032);
    chk(sn_wb && sn_wa == 12'h032 && sn_wd == 32'h3333_0003, "R6 snoop read on M flushes",
        sn_wd, 32'h3333_0003);
    chk(sn_sh, "R8 shared asserted for M", sn_sh, 1);
    cpu_op(1, 12'h032, 32'h3333_0004);
    chk(n_bus == 1 && lg_cmd[0] == RDX, "R6 M became S", n_bus, 1);
  endtask

  task automatic t_snoop_rd_e();
    shr_drive = 0;
    cpu_op(0, 12'h043, 0);
    snoop(RD, 12'h043);
    chk(!sn_wb && sn_sh, "R6 snoop read on E no flush, R8 shared", {sn_wb, sn_sh}, 2'b01);
    cpu_op(1, 12'h043, 32'h4444_0004);
    chk(n_bus == 1 && lg_cmd[0] == RDX, "R6 E became S", n_bus, 1);
  endtask

  task automatic t_snoop_rdx();
    cpu_op(1, 12'h054, 32'h5555_0005);
    snoop(RDX, 12'h054);
    chk(sn_wb && sn_wd == 32'h5555_0005, "R7 RdX on M flushes", sn_wd, 32'h5555_0005);
    chk(!sn_sh, "R8 no shared on RdX", sn_sh, 0);
    cpu_op(0, 12'h054, 0);
    chk(n_bus == 1 && lg_cmd[0] == RD, "R7 M invalidated", n_bus, 1);
    shr_drive = 1;
    cpu_op(0, 12'h065, 0);
    shr_drive = 0;
    snoop(RDX, 12'h065);
    chk(!sn_wb, "R7 RdX on S no flush", sn_wb, 0);
    cpu_op(0, 12'h065, 0);
    chk(n_bus == 1 && lg_cmd[0] == RD, "R7 S invalidated", n_bus, 1);
  endtask

  task automatic t_tag_miss();
    snoop(RDX, 12'h110);
    chk(!sn_wb && !sn_sh, "R11 other tag no flush/shared", {sn_wb, sn_sh}, 0);
    cpu_op(0, 12'h010, 0);
    chk(n_bus == 0 && op_rdata == 32'h1111_0001, "R11 line untouched", op_rdata, 32'h1111_0001);
  endtask

  task automatic t_evict();
    cpu_op(0, 12'h110, 0);
    chk(n_bus == 2 && lg_cmd[0] == FL && lg_adr[0] == 12'h010 && lg_dat[0] == 32'h1111_0001,
        "R9 dirty victim written back", lg_dat[0], 32'h1111_0001);
    chk(lg_cmd[1] == RD && lg_adr[1] == 12'h110 && op_rdata == pat(12'h110),
        "R9 fill after write-back", op_rdata, pat(12'h110));
    cpu_op(0, 12'h210, 0);
    chk(n_bus == 1 && lg_cmd[0] == RD, "R9 clean victim silent", n_bus, 1);
  endtask

  task automatic t_priority();
    cpu_op(1, 12'h076, 32'h7777_0007);
    n_bus = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 12'h076;
    snp_valid = 1; snp_cmd = RDX; snp_addr = 12'h076;
    @(negedge clk);
    sn_wb = wb_valid; sn_wd = wb_data;
    snp_valid = 0; snp_cmd = 0;
    op_cyc = 1;
    while (!cpu_done && op_cyc < 200) begin
      @(negedge clk);
      op_cyc++;
    end
    op_rdata = cpu_rdata;
    cpu_req = 0;
    chk(sn_wb && sn_wd == 32'h7777_0007, "R10 snoop applied first", sn_wd, 32'h7777_0007);
    chk(n_bus == 1 && lg_cmd[0] == RD && op_rdata == pat(12'h076),
        "R10 load replayed as miss", op_rdata, pat(12'h076));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    snp_valid = 0; snp_cmd = 0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_read_excl();
    t_read_shared();
    t_snoop_rd_m();
    t_snoop_rd_e();
    t_snoop_rdx();
    t_tag_miss();
    t_evict();
    t_priority();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule